// File: doc/BRIEF.md
# UART Status Flag Register

This block holds the 16-bit status word of an asynchronous serial port. The receiver and transmitter report events to it as single-cycle strobes: a received character with its ninth data bit, framing, parity and overrun errors, and short and long break detections. The block turns each strobe into a flag. It also tracks whether the transmit holding register and the transmit shift register are empty, and shows the synchronized, inverted clear-to-send pin as a handshake bit.

Software reads the word through a plain bus port that has a two-bit register select. A read that selects the receive data register clears the data-ready flag and emits a pop pulse. A write that selects the transmit data register clears the holding-empty flag and emits a push pulse. The error and break flags are sticky. Only a software write of 0 to the matching bit of the status word clears them. The bus has no back-pressure: every strobe acts in the cycle it is presented.

Top module: `uart_status_reg`

## Requirements
- R1: The status word places long break at bit 10, short break at bit 9, received ninth bit at bit 8, data ready at bit 7, holding empty at bit 6, framing error at bit 5, overrun at bit 4, parity error at bit 3, transmitter empty at bit 2 and handshake at bit 1. Bits 15..11 and bit 0 always read 0.
- R2: A `rx_done` strobe sets data ready (bit 7) from the next cycle. A bus read with `bus_sel`=1 (receive data) raises `rx_pop` in the same cycle and clears bit 7 from the next cycle. If the read and `rx_done` come in the same cycle, bit 7 stays set.
- R3: A bus write with `bus_sel`=2 (transmit data) raises `tx_push` in the same cycle and clears holding empty (bit 6) from the next cycle. A `thr_free` strobe sets bit 6. If the write and `thr_free` come in the same cycle, bit 6 ends clear.
- R4: Transmitter empty (bit 2) equals `tsr_idle` as sampled at the previous clock edge.
- R5: Handshake (bit 1) is the inverse of `cts_n` after two register stages. A change on `cts_n` shows on bit 1 after the second rising edge.
- R6: The framing, overrun, short-break and long-break strobes set bits 5, 4, 9 and 10, in any mode. Each of these bits then stays set until a status write (`bus_sel`=0) carries 0 in that bit.
- R7: A status write with 1 in a sticky bit leaves that bit as it is. A status write has no effect on bits 7, 6, 2 and 1 or on the reserved bits.
- R8: Bit 8 is set by `rx_done` with `rx_bit9`=1 only when `mode` is 2 or 3 (`mode[1]`=1). In modes 0 and 1 it is not changed. It is sticky, as in R6.
- R9: `rx_parity_err` sets bit 3 only when `mode` is 1 or 3 (`mode[0]`=1). In modes 0 and 2 it is ignored. It is sticky, as in R6.
- R10: When a sticky flag's set strobe and a status write of 0 to that bit come in the same cycle, the flag ends set.
- R11: After reset the status word reads 16'h0044: holding empty and transmitter empty are 1 and every other bit is 0. The handshake synchronizer resets to the no-clear-to-send state.
- R12: `bus_rdata` carries the status word when `bus_sel`=0 and is 0 for every other select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | 1 | Received character complete strobe |
| rx_bit9 | input | 1 | Ninth data bit of the received character |
| rx_frame_err | input | 1 | Framing error strobe |
| rx_parity_err | input | 1 | Parity error strobe |
| rx_overrun | input | 1 | Overrun error strobe |
| brk_short | input | 1 | Short break detected strobe |
| brk_long | input | 1 | Long break detected strobe |
| thr_free | input | 1 | Holding register moved to the shifter strobe |
| tsr_idle | input | 1 | Transmit shift register holds no data |
| cts_n | input | 1 | External clear-to-send pin, active low, asynchronous |
| mode | input | 2 | Serial mode 0..3 |
| bus_sel | input | 2 | Register select: 0 status, 1 receive data, 2 transmit data, 3 none |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data |
| rx_pop | output | 1 | Receive data register is being read |
| tx_push | output | 1 | Transmit data register is being written |

## Verification
Several functions can act in the same cycle. A flag's set strobe can meet a software status write that clears it, `rx_done` can meet a read of the receive data register, and `thr_free` can meet a write to the transmit data register. Directed steps force each of these pairs into a single cycle. A long random phase then fires the strobes and bus accesses together at independent rates. In every cycle a behavioural model in the bench sets the winner of each pair, set for the sticky flags and data ready, clear for holding empty, and checks every bit of the readback against the model.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W = 16;

  localparam int B_BRK_LONG  = 10;
  localparam int B_BRK_SHORT = 9;
  localparam int B_RX9       = 8;
  localparam int B_RDR       = 7;
  localparam int B_THRE      = 6;
  localparam int B_FER       = 5;
  localparam int B_OER       = 4;
  localparam int B_PER       = 3;
  localparam int B_TEMT      = 2;
  localparam int B_HS        = 1;

  localparam int N_STICKY = 6;

  localparam logic [STAT_W-1:0] STICKY_MASK =
    (STAT_W'(1) << B_BRK_LONG) | (STAT_W'(1) << B_BRK_SHORT) |
    (STAT_W'(1) << B_RX9) | (STAT_W'(1) << B_FER) |
    (STAT_W'(1) << B_OER) | (STAT_W'(1) << B_PER);

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_RXDATA = 2'd1,
    SEL_TXDATA = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/uart_stat_sticky.sv
module uart_stat_sticky #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag[i] <= 1'b0;
      else if (set_ev[i])  flag[i] <= 1'b1;   // set beats clear
      else if (clr_req[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_stat_xfer.sv
module uart_stat_xfer (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_done,
  input  logic rx_pop,
  input  logic thr_free,
  input  logic tx_push,
  input  logic tsr_idle,
  output logic rdr,
  output logic thre,
  output logic temt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr  <= 1'b0;
      thre <= 1'b1;
      temt <= 1'b1;
    end else begin
      if (rx_done)     rdr <= 1'b1;
      else if (rx_pop) rdr <= 1'b0;
      if (tx_push)       thre <= 1'b0;
      else if (thr_free) thre <= 1'b1;
      temt <= tsr_idle;
    end
  end
endmodule

// File: rtl/uart_stat_sync.sv
module uart_stat_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_status_reg.sv
module uart_status_reg
  import uart_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic              rx_bit9,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              rx_overrun,
  input  logic              brk_short,
  input  logic              brk_long,
  input  logic              thr_free,
  input  logic              tsr_idle,
  input  logic              cts_n,
  input  logic [1:0]        mode,
  input  logic [1:0]        bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [STAT_W-1:0] bus_rdata,
  output logic              rx_pop,
  output logic              tx_push
);
  logic stat_wr;
  logic [N_STICKY-1:0] set_vec, clr_vec, sticky;
  logic rdr, thre, temt, cts_sync;
  logic [STAT_W-1:0] status_word;

  assign stat_wr = bus_wr && (bus_sel == SEL_STATUS);
  assign rx_pop  = bus_rd && (bus_sel == SEL_RXDATA);
  assign tx_push = bus_wr && (bus_sel == SEL_TXDATA);

  // sticky slots: 0 parity, 1 overrun, 2 framing, 3 ninth bit, 4 short brk, 5 long brk
  assign set_vec[0] = rx_parity_err && mode[0];
  assign set_vec[1] = rx_overrun;
  assign set_vec[2] = rx_frame_err;
  assign set_vec[3] = rx_done && rx_bit9 && mode[1];
  assign set_vec[4] = brk_short;
  assign set_vec[5] = brk_long;

  assign clr_vec[0] = stat_wr && !bus_wdata[B_PER];
  assign clr_vec[1] = stat_wr && !bus_wdata[B_OER];
  assign clr_vec[2] = stat_wr && !bus_wdata[B_FER];
  assign clr_vec[3] = stat_wr && !bus_wdata[B_RX9];
  assign clr_vec[4] = stat_wr && !bus_wdata[B_BRK_SHORT];
  assign clr_vec[5] = stat_wr && !bus_wdata[B_BRK_LONG];

  uart_stat_sticky #(.N(N_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_ev(set_vec), .clr_req(clr_vec), .flag(sticky)
  );

  uart_stat_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_pop(rx_pop),
    .thr_free(thr_free), .tx_push(tx_push), .tsr_idle(tsr_idle),
    .rdr(rdr), .thre(thre), .temt(temt)
  );

  uart_stat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts (
    .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_sync)
  );

  always_comb begin
    status_word              = '0;
    status_word[B_PER]       = sticky[0];
    status_word[B_OER]       = sticky[1];
    status_word[B_FER]       = sticky[2];
    status_word[B_RX9]       = sticky[3];
    status_word[B_BRK_SHORT] = sticky[4];
    status_word[B_BRK_LONG]  = sticky[5];
    status_word[B_RDR]       = rdr;
    status_word[B_THRE]      = thre;
    status_word[B_TEMT]      = temt;
    status_word[B_HS]        = !cts_sync;
  end

  assign bus_rdata = (bus_sel == SEL_STATUS) ? status_word : '0;
endmodule

// File: rtl/uart_status_reg_chk.sv
module uart_status_reg_chk
  import uart_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_done,
  input logic              rx_bit9,
  input logic              rx_frame_err,
  input logic              rx_parity_err,
  input logic [1:0]        mode,
  input logic              stat_wr,
  input logic              rx_pop,
  input logic              tx_push,
  input logic              thr_free,
  input logic [STAT_W-1:0] status_word
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[15:11] == 5'd0) && (status_word[0] == 1'b0));

  assert_rdr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> status_word[B_RDR]);

  assert_rdr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_done) |=> !status_word[B_RDR]);

  assert_thre_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !status_word[B_THRE]);

  assert_thre_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_free && !tx_push) |=> status_word[B_THRE]);

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_word & STICKY_MASK & $past(status_word))
                  == ($past(status_word) & STICKY_MASK)));

  assert_rx9_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_word[B_RX9] && !(rx_done && rx_bit9 && mode[1])) |=> !status_word[B_RX9]);

  assert_parity_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_word[B_PER] && !(rx_parity_err && mode[0])) |=> !status_word[B_PER]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |=> status_word[B_FER]);
endmodule

bind uart_status_reg uart_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_bit9(rx_bit9),
  .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err), .mode(mode),
  .stat_wr(stat_wr), .rx_pop(rx_pop), .tx_push(tx_push), .thr_free(thr_free),
  .status_word(status_word)
);

// File: tb/uart_status_reg_test.sv
`timescale 1ns/1ps
module uart_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_done = 0, rx_bit9 = 0, rx_frame_err = 0, rx_parity_err = 0, rx_overrun = 0;
  logic brk_short = 0, brk_long = 0, thr_free = 0, tsr_idle = 1, cts_n = 1;
  logic [1:0] mode = 2'd0, bus_sel = 2'd0;
  logic bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic rx_pop, tx_push;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  uart_status_reg uut (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_bit9(rx_bit9),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .rx_overrun(rx_overrun), .brk_short(brk_short), .brk_long(brk_long),
    .thr_free(thr_free), .tsr_idle(tsr_idle), .cts_n(cts_n), .mode(mode),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_pop(rx_pop), .tx_push(tx_push)
  );

  // behavioural reference state
  bit m_brk_l, m_brk_s, m_rx9, m_rdr, m_thre, m_fer, m_oer, m_per, m_temt;
  bit cts_hist[$];

  function automatic logic [15:0] model_word();
    logic [15:0] w = 16'h0;
    w[10] = m_brk_l; w[9] = m_brk_s; w[8] = m_rx9; w[7] = m_rdr;
    w[6] = m_thre;   w[5] = m_fer;   w[4] = m_oer;  w[3] = m_per;
    w[2] = m_temt;   w[1] = !cts_hist[1];
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_brk_l, m_brk_s, m_rx9, m_rdr, m_fer, m_oer, m_per} = '0;
      m_thre = 1; m_temt = 1;
      cts_hist = '{1'b1, 1'b1};
    end else begin
      bit swr;
      swr = bus_wr && bus_sel == 2'd0;
      if (swr) begin
        if (!bus_wdata[10]) m_brk_l = 0;
        if (!bus_wdata[9])  m_brk_s = 0;
        if (!bus_wdata[8])  m_rx9 = 0;
        if (!bus_wdata[5])  m_fer = 0;
        if (!bus_wdata[4])  m_oer = 0;
        if (!bus_wdata[3])  m_per = 0;
      end
      if (brk_long) m_brk_l = 1;
      if (brk_short) m_brk_s = 1;
      if (rx_done && rx_bit9 && (mode == 2 || mode == 3)) m_rx9 = 1;
      if (rx_frame_err) m_fer = 1;
      if (rx_overrun) m_oer = 1;
      if (rx_parity_err && (mode == 1 || mode == 3)) m_per = 1;
      if (bus_rd && bus_sel == 2'd1) m_rdr = 0;
      if (rx_done) m_rdr = 1;
      if (thr_free) m_thre = 1;
      if (bus_wr && bus_sel == 2'd2) m_thre = 0;
      m_temt = tsr_idle;
      cts_hist.push_front(cts_n);
      void'(cts_hist.pop_back());
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int b, input logic [1:0] sel);
    if (sel != 2'd0) return "R12 readback zero";
    case (b)
      10, 9, 5, 4: return "R6 sticky flag";
      8:           return "R8 ninth bit";
      7:           return "R2 data ready";
      6:           return "R3 holding empty";
      3:           return "R9 parity";
      2:           return "R4 transmitter empty";
      1:           return "R5 handshake";
      default:     return "R1 reserved bit";
    endcase
  endfunction

  task automatic compare_all();
    logic [15:0] exp_rd;
    exp_rd = (bus_sel == 2'd0) ? model_word() : 16'h0;
    for (int b = 0; b < 16; b++) chk(16'(bus_rdata[b]), 16'(exp_rd[b]), tag_of(b, bus_sel));
    chk(16'(rx_pop), 16'(bus_rd && bus_sel == 2'd1), "R2 rx_pop");
    chk(16'(tx_push), 16'(bus_wr && bus_sel == 2'd2), "R3 tx_push");
  endtask

  // one cycle: wait for negedge, compare, then drop all strobes
  task automatic cyc();
    @(negedge clk);
    compare_all();
    {rx_done, rx_bit9, rx_frame_err, rx_parity_err, rx_overrun} = '0;
    {brk_short, brk_long, thr_free, bus_rd, bus_wr} = '0;
    bus_sel = 2'd0; bus_wdata = 16'h0;
  endtask

  task automatic wr_status(input logic [15:0] d);
    bus_wr = 1; bus_sel = 2'd0; bus_wdata = d;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R0 watchdog expired actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk(bus_rdata, 16'h0044, "R11 reset value");

    // R6 R8 R9: set every sticky flag in mode 3
    mode = 2'd3;
    rx_frame_err = 1; rx_overrun = 1; brk_short = 1; brk_long = 1;
    rx_done = 1; rx_bit9 = 1; rx_parity_err = 1;
    cyc();
    #1 chk(bus_rdata, 16'h07FC, "R6 all sticky set");

    // R7: writing ones changes nothing
    wr_status(16'hFFFF);
    cyc();
    #1 chk(bus_rdata, 16'h07FC, "R7 write ones no effect");

    // R10: clear-all write with a framing strobe in the same cycle
    wr_status(16'h0000); rx_frame_err = 1;
    cyc();
    #1 chk(bus_rdata, 16'h00E4, "R10 set wins over clear");
    wr_status(16'h0000);
    cyc();

    // R8 R9 mode gating
    mode = 2'd0; rx_done = 1; rx_bit9 = 1; rx_parity_err = 1;
    cyc();
    #1 chk(16'(bus_rdata[8]), 16'h0, "R8 mode 0 ignores ninth bit");
    chk(16'(bus_rdata[3]), 16'h0, "R9 mode 0 ignores parity");
    mode = 2'd1; rx_done = 1; rx_bit9 = 1; rx_parity_err = 1;
    cyc();
    #1 chk(16'(bus_rdata[8]), 16'h0, "R8 mode 1 ignores ninth bit");
    chk(16'(bus_rdata[3]), 16'h1, "R9 mode 1 parity");
    wr_status(16'h0000);
    cyc();
    mode = 2'd2; rx_done = 1; rx_bit9 = 1; rx_parity_err = 1;
    cyc();
    #1 chk(16'(bus_rdata[8]), 16'h1, "R8 mode 2 ninth bit");
    chk(16'(bus_rdata[3]), 16'h0, "R9 mode 2 ignores parity");

    // R2: read of receive data clears ready; read plus new char keeps it
    bus_rd = 1; bus_sel = 2'd1;
    cyc();
    #1 chk(16'(bus_rdata[7]), 16'h0, "R2 read clears ready");
    bus_rd = 1; bus_sel = 2'd1; rx_done = 1;
    cyc();
    #1 chk(16'(bus_rdata[7]), 16'h1, "R2 new char beats read");

    // R3: transmit write clears, free sets, both together clears
    bus_wr = 1; bus_sel = 2'd2;
    cyc();
    #1 chk(16'(bus_rdata[6]), 16'h0, "R3 write clears empty");
    thr_free = 1;
    cyc();
    #1 chk(16'(bus_rdata[6]), 16'h1, "R3 free sets empty");
    bus_wr = 1; bus_sel = 2'd2; thr_free = 1;
    cyc();
    #1 chk(16'(bus_rdata[6]), 16'h0, "R3 write beats free");

    // R4 and R5
    tsr_idle = 0; cts_n = 0;
    cyc();
    #1 chk(16'(bus_rdata[2]), 16'h0, "R4 shifter busy");
    chk(16'(bus_rdata[1]), 16'h0, "R5 one stage not yet");
    cyc();
    #1 chk(16'(bus_rdata[1]), 16'h1, "R5 handshake after two stages");

    // R12: other selects read zero
    bus_sel = 2'd3;
    #1 chk(bus_rdata, 16'h0, "R12 select 3 reads zero");
    cyc();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 49) == 0) mode = 2'($urandom);
      if ($urandom_range(0, 19) == 0) cts_n = ~cts_n;
      if ($urandom_range(0, 9) == 0) tsr_idle = ~tsr_idle;
      rx_done       = ($urandom_range(0, 5) == 0);
      rx_bit9       = $urandom_range(0, 1) == 1;
      rx_frame_err  = ($urandom_range(0, 11) == 0);
      rx_parity_err = ($urandom_range(0, 7) == 0);
      rx_overrun    = ($urandom_range(0, 11) == 0);
      brk_short     = ($urandom_range(0, 15) == 0);
      brk_long      = ($urandom_range(0, 19) == 0);
      thr_free      = ($urandom_range(0, 4) == 0);
      bus_sel       = 2'($urandom);
      bus_rd        = ($urandom_range(0, 3) == 0);
      bus_wr        = ($urandom_range(0, 3) == 0);
      bus_wdata     = 16'($urandom);
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule